// File: doc/BRIEF.md
# Coherence-Snooping Speculative Store Buffer

This block keeps one core's stores in a small ordered queue while they are still speculative, that is, before they retire. It behaves like a tiny coherent cache for that speculative state. Each store comes in with its reorder-buffer age, a line address, data, and a flag that says whether the local cache currently holds the line in shared state. A younger load that hits a buffered line takes its data from the youngest older store to that line. Each load served this way is recorded in a tracking table until it retires.

A two-state ownership controller asks the coherence fabric for write ownership of each buffered store's line, oldest first. In state S_IDLE it picks the oldest unowned entry (transition IDLE_TO_REQ). In state S_REQ it holds the request until the grant arrives (transition REQ_TO_IDLE, which marks every entry of that age as owned). The request is tagged as a read-upgrade when the line was shared. The head store leaves the buffer, in program order, only once its ownership bit is set and the pipeline allows it.

Every invalidation snooped from the local cache is compared against all tracked loads in one cycle. On a match the block signals a squash at the oldest matching age, and every store entry and tracked load of that age or younger is discarded. The same invalidation also removes ownership from buffered stores to the line, so those stores must ask again.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the buffer and the tracking table are empty, st_full_o, own_req_o, st_ret_o and squash_o are low.
- R2: A load (ld_vld_i) returns ld_hit_o=1 with the data of the youngest buffered store whose line address equals ld_addr_i and whose age is smaller than ld_age_i (ages compare as unsigned, larger is younger). With no such store, ld_hit_o=0.
- R3: st_full_o is high while all DEPTH entries are held. A store presented while st_full_o is high is dropped.
- R4: The controller moves from S_IDLE to S_REQ by picking the oldest unowned entry. It then drives own_req_o with that line on own_addr_o, and own_upg_o equal to the shared flag the entry holds. The request stays high and stable until own_gnt_i. The grant sets ownership and returns to S_IDLE.
- R5: st_ret_o pulses with the head store's address and data only when ret_ok_i is high and the head is owned. The head is then removed, so the stores leave in age order.
- R6: A snooped invalidation (snp_vld_i) whose line matches any tracked load raises squash_o one cycle later, with squash_age_o set to the oldest matching load age.
- R7: On that squash, all store entries and tracked loads with age at or above the squash age are discarded.
- R8: An invalidation clears ownership and the shared flag of buffered stores to that line. It blocks their retirement in that same cycle. Ownership is then requested again with own_upg_o=0.
- R9: A load retired through ld_ret_i and ld_ret_age_i is no longer tracked. Invalidations of its line, or of lines no tracked load uses, cause no squash.
- R10: A load that takes forwarded data in the same cycle as an invalidation of its line is squashed at its own age.
- R11: When the tracking table is full, a load that would take forwarded data raises ld_stall_o with ld_hit_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_vld_i | input | 1 | Store issue |
| st_age_i | input | AGE_W | Store age |
| st_addr_i | input | ADDR_W | Store line address |
| st_data_i | input | DATA_W | Store data |
| st_shared_i | input | 1 | Line held shared at issue |
| st_full_o | output | 1 | Buffer full, stall stores |
| ld_vld_i | input | 1 | Load lookup |
| ld_age_i | input | AGE_W | Load age |
| ld_addr_i | input | ADDR_W | Load line address |
| ld_hit_o | output | 1 | Forwarded data valid |
| ld_data_o | output | DATA_W | Forwarded data |
| ld_stall_o | output | 1 | Forward blocked, tracking full |
| ld_ret_i | input | 1 | Load retires |
| ld_ret_age_i | input | AGE_W | Age of retiring load |
| own_req_o | output | 1 | Ownership request |
| own_addr_o | output | ADDR_W | Requested line |
| own_upg_o | output | 1 | Request is a read-upgrade |
| own_gnt_i | input | 1 | Ownership granted |
| snp_vld_i | input | 1 | Snooped invalidation |
| snp_addr_i | input | ADDR_W | Invalidated line |
| ret_ok_i | input | 1 | Head store may retire |
| st_ret_o | output | 1 | Head store retires |
| st_ret_addr_o | output | ADDR_W | Retiring store line |
| st_ret_data_o | output | DATA_W | Retiring store data |
| squash_o | output | 1 | Squash request |
| squash_age_o | output | AGE_W | Oldest age to squash |

## Verification
The properties assume a few things about the inputs. Stores arrive in increasing age order. own_gnt_i is raised only while own_req_o is high. Ages do not wrap while entries are live. st_vld_i stays low while st_full_o is high, except when a deliberate dropped-store case is being tested. The directed tasks keep to these rules. Each scenario starts from a fresh reset with small ascending ages. Grants are issued only after the bench has seen own_req_o high. Every load forward, snoop and retire happens at a falling edge and is checked before the next rising edge.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_REQ  = 1'b1
    } own_state_e;
endpackage

// File: rtl/ssb_store_q.sv
module ssb_store_q #(
    parameter int DEPTH  = 4,
    parameter int AGE_W  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_vld_i,
    input  logic [AGE_W-1:0]  st_age_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              st_shared_i,
    input  logic [AGE_W-1:0]  ld_age_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              fwd_hit_o,
    output logic [DATA_W-1:0] fwd_data_o,
    input  logic              gnt_vld_i,
    input  logic [AGE_W-1:0]  gnt_age_i,
    input  logic              snp_vld_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              flush_vld_i,
    input  logic [AGE_W-1:0]  flush_age_i,
    input  logic              ret_ok_i,
    output logic              ret_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic [DATA_W-1:0] ret_data_o,
    output logic              head_own_o,
    output logic              full_o,
    output logic              pick_vld_o,
    output logic [AGE_W-1:0]  pick_age_o,
    output logic [ADDR_W-1:0] pick_addr_o,
    output logic              pick_shr_o
);
    typedef struct packed {
        logic              v;
        logic              own;
        logic              shr;
        logic [AGE_W-1:0]  age;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ent_t;

    ent_t q [DEPTH];
    ent_t n [DEPTH];
    logic placed;
    logic head_lost, head_flush;

    // Youngest older matching entry wins: index order equals age order.
    always_comb begin
        fwd_hit_o  = 1'b0;
        fwd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q[i].v && q[i].addr == ld_addr_i && q[i].age < ld_age_i) begin
                fwd_hit_o  = 1'b1;
                fwd_data_o = q[i].data;
            end
        end
    end

    // Oldest entry still lacking ownership.
    always_comb begin
        pick_vld_o  = 1'b0;
        pick_age_o  = '0;
        pick_addr_o = '0;
        pick_shr_o  = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (q[i].v && !q[i].own) begin
                pick_vld_o  = 1'b1;
                pick_age_o  = q[i].age;
                pick_addr_o = q[i].addr;
                pick_shr_o  = q[i].shr;
            end
        end
    end

    assign head_lost  = snp_vld_i && q[0].addr == snp_addr_i;
    assign head_flush = flush_vld_i && q[0].age >= flush_age_i;
    assign ret_o      = ret_ok_i && q[0].v && q[0].own && !head_lost && !head_flush;
    assign ret_addr_o = q[0].addr;
    assign ret_data_o = q[0].data;
    assign head_own_o = q[0].v && q[0].own;
    assign full_o     = q[DEPTH-1].v;

    always_comb begin
        placed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            n[i] = q[i];
            if (n[i].v && gnt_vld_i && n[i].age == gnt_age_i)
                n[i].own = 1'b1;
            if (snp_vld_i && n[i].addr == snp_addr_i) begin
                n[i].own = 1'b0;
                n[i].shr = 1'b0;
            end
            if (flush_vld_i && n[i].age >= flush_age_i)
                n[i].v = 1'b0;
        end
        if (ret_o) begin
            for (int i = 0; i < DEPTH - 1; i++)
                n[i] = n[i+1];
            n[DEPTH-1] = '0;
        end
        if (st_vld_i && !full_o && !(flush_vld_i && st_age_i >= flush_age_i)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !n[i].v) begin
                    n[i].v    = 1'b1;
                    n[i].own  = 1'b0;
                    n[i].shr  = st_shared_i;
                    n[i].age  = st_age_i;
                    n[i].addr = st_addr_i;
                    n[i].data = st_data_i;
                    placed    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) q[i] <= '0;
            else        q[i] <= n[i];
        end
    end
endmodule

// File: rtl/ssb_load_trk.sv
module ssb_load_trk #(
    parameter int DEPTH  = 4,
    parameter int AGE_W  = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_vld_i,
    input  logic [AGE_W-1:0]  ld_age_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              ret_vld_i,
    input  logic [AGE_W-1:0]  ret_age_i,
    input  logic              snp_vld_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              full_o,
    output logic              sq_now_o,
    output logic [AGE_W-1:0]  sq_age_o,
    output logic              squash_o,
    output logic [AGE_W-1:0]  squash_age_o
);
    logic [DEPTH-1:0]  v_q, v_n;
    logic [AGE_W-1:0]  age_q  [DEPTH];
    logic [AGE_W-1:0]  age_n  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [ADDR_W-1:0] addr_n [DEPTH];
    logic              placed;

    assign full_o = &v_q;

    // Oldest tracked or incoming forwarded load on the invalidated line.
    always_comb begin
        sq_now_o = 1'b0;
        sq_age_o = '1;
        if (snp_vld_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (v_q[i] && addr_q[i] == snp_addr_i && (!sq_now_o || age_q[i] < sq_age_o)) begin
                    sq_now_o = 1'b1;
                    sq_age_o = age_q[i];
                end
            end
            if (alloc_vld_i && ld_addr_i == snp_addr_i && (!sq_now_o || ld_age_i < sq_age_o)) begin
                sq_now_o = 1'b1;
                sq_age_o = ld_age_i;
            end
        end
    end

    always_comb begin
        placed = 1'b0;
        v_n    = v_q;
        for (int i = 0; i < DEPTH; i++) begin
            age_n[i]  = age_q[i];
            addr_n[i] = addr_q[i];
            if (ret_vld_i && age_q[i] == ret_age_i)
                v_n[i] = 1'b0;
            if (sq_now_o && age_q[i] >= sq_age_o)
                v_n[i] = 1'b0;
        end
        if (alloc_vld_i && !(sq_now_o && ld_age_i >= sq_age_o)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !v_n[i]) begin
                    v_n[i]    = 1'b1;
                    age_n[i]  = ld_age_i;
                    addr_n[i] = ld_addr_i;
                    placed    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q          <= '0;
            squash_o     <= 1'b0;
            squash_age_o <= '0;
        end else begin
            v_q          <= v_n;
            squash_o     <= sq_now_o;
            squash_age_o <= sq_age_o;
        end
        for (int i = 0; i < DEPTH; i++) begin
            age_q[i]  <= rst_n ? age_n[i]  : '0;
            addr_q[i] <= rst_n ? addr_n[i] : '0;
        end
    end
endmodule

// File: rtl/ssb_own_fsm.sv
module ssb_own_fsm #(
    parameter int AGE_W  = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pick_vld_i,
    input  logic [AGE_W-1:0]  pick_age_i,
    input  logic [ADDR_W-1:0] pick_addr_i,
    input  logic              pick_shr_i,
    input  logic              gnt_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              upg_o,
    output logic              gnt_vld_o,
    output logic [AGE_W-1:0]  gnt_age_o
);
    import ssb_pkg::*;

    own_state_e        st_q, st_n;
    logic [AGE_W-1:0]  age_q;
    logic [ADDR_W-1:0] addr_q;
    logic              upg_q;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            S_IDLE: if (pick_vld_i) st_n = S_REQ;
            S_REQ:  if (gnt_i)      st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q  <= '0;
            addr_q <= '0;
            upg_q  <= 1'b0;
        end else if (st_q == S_IDLE && pick_vld_i) begin
            age_q  <= pick_age_i;
            addr_q <= pick_addr_i;
            upg_q  <= pick_shr_i;
        end
    end

    always_comb begin
        req_o     = (st_q == S_REQ);
        gnt_vld_o = (st_q == S_REQ) && gnt_i;
        addr_o    = addr_q;
        upg_o     = upg_q;
        gnt_age_o = age_q;
    end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
    parameter int SQ_DEPTH = 4,
    parameter int LT_DEPTH = 4,
    parameter int AGE_W    = 6,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_vld_i,
    input  logic [AGE_W-1:0]  st_age_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              st_shared_i,
    output logic              st_full_o,
    input  logic              ld_vld_i,
    input  logic [AGE_W-1:0]  ld_age_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              ld_hit_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              ld_stall_o,
    input  logic              ld_ret_i,
    input  logic [AGE_W-1:0]  ld_ret_age_i,
    output logic              own_req_o,
    output logic [ADDR_W-1:0] own_addr_o,
    output logic              own_upg_o,
    input  logic              own_gnt_i,
    input  logic              snp_vld_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              ret_ok_i,
    output logic              st_ret_o,
    output logic [ADDR_W-1:0] st_ret_addr_o,
    output logic [DATA_W-1:0] st_ret_data_o,
    output logic              squash_o,
    output logic [AGE_W-1:0]  squash_age_o
);
    logic              fwd_hit;
    logic [DATA_W-1:0] fwd_data;
    logic              trk_full;
    logic              sq_now;
    logic [AGE_W-1:0]  sq_age;
    logic              gnt_vld;
    logic [AGE_W-1:0]  gnt_age;
    logic              pick_vld, pick_shr;
    logic [AGE_W-1:0]  pick_age;
    logic [ADDR_W-1:0] pick_addr;
    logic              sq_head_own;

    assign ld_hit_o   = ld_vld_i && fwd_hit && !trk_full;
    assign ld_stall_o = ld_vld_i && fwd_hit && trk_full;
    assign ld_data_o  = fwd_data;

    ssb_store_q #(.DEPTH(SQ_DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .st_vld_i(st_vld_i), .st_age_i(st_age_i), .st_addr_i(st_addr_i),
        .st_data_i(st_data_i), .st_shared_i(st_shared_i),
        .ld_age_i(ld_age_i), .ld_addr_i(ld_addr_i),
        .fwd_hit_o(fwd_hit), .fwd_data_o(fwd_data),
        .gnt_vld_i(gnt_vld), .gnt_age_i(gnt_age),
        .snp_vld_i(snp_vld_i), .snp_addr_i(snp_addr_i),
        .flush_vld_i(sq_now), .flush_age_i(sq_age),
        .ret_ok_i(ret_ok_i), .ret_o(st_ret_o),
        .ret_addr_o(st_ret_addr_o), .ret_data_o(st_ret_data_o),
        .head_own_o(sq_head_own), .full_o(st_full_o),
        .pick_vld_o(pick_vld), .pick_age_o(pick_age),
        .pick_addr_o(pick_addr), .pick_shr_o(pick_shr)
    );

    ssb_load_trk #(.DEPTH(LT_DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .alloc_vld_i(ld_hit_o), .ld_age_i(ld_age_i), .ld_addr_i(ld_addr_i),
        .ret_vld_i(ld_ret_i), .ret_age_i(ld_ret_age_i),
        .snp_vld_i(snp_vld_i), .snp_addr_i(snp_addr_i),
        .full_o(trk_full), .sq_now_o(sq_now), .sq_age_o(sq_age),
        .squash_o(squash_o), .squash_age_o(squash_age_o)
    );

    ssb_own_fsm #(.AGE_W(AGE_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pick_vld_i(pick_vld), .pick_age_i(pick_age),
        .pick_addr_i(pick_addr), .pick_shr_i(pick_shr),
        .gnt_i(own_gnt_i), .req_o(own_req_o), .addr_o(own_addr_o),
        .upg_o(own_upg_o), .gnt_vld_o(gnt_vld), .gnt_age_o(gnt_age)
    );
endmodule

// File: rtl/spec_store_buf_chk.sv
module spec_store_buf_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              own_req_o,
    input logic              own_gnt_i,
    input logic [ADDR_W-1:0] own_addr_o,
    input logic              st_ret_o,
    input logic              sq_head_own,
    input logic              squash_o,
    input logic              snp_vld_i,
    input logic              ld_stall_o,
    input logic              ld_hit_o,
    input logic              st_full_o
);
    // R5: a store leaves only with ownership held by the queue head
    p_ret_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_ret_o |-> sq_head_own);

    // R4: request held and stable until granted
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        own_req_o && !own_gnt_i |=> own_req_o && $stable(own_addr_o));

    // R4: grant returns the controller to idle
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        own_req_o && own_gnt_i |=> !own_req_o);

    // R6: a squash always follows a snooped invalidation
    p_squash_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> $past(snp_vld_i));

    // R11: a stalled load never reports forwarded data
    p_stall_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall_o |-> !ld_hit_o);

    // R3: a full buffer stays full unless something leaves
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_full_o && !st_ret_o && !snp_vld_i |=> st_full_o);
endmodule

bind spec_store_buf spec_store_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .own_req_o(own_req_o), .own_gnt_i(own_gnt_i), .own_addr_o(own_addr_o),
    .st_ret_o(st_ret_o), .sq_head_own(sq_head_own),
    .squash_o(squash_o), .snp_vld_i(snp_vld_i),
    .ld_stall_o(ld_stall_o), .ld_hit_o(ld_hit_o), .st_full_o(st_full_o)
);

// File: tb/spec_store_buf_test.sv
module spec_store_buf_test;
    localparam int CLK_PERIOD = 10;
    localparam int AGE_W = 6;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_vld_i = 0, st_shared_i = 0, ld_vld_i = 0, ld_ret_i = 0;
    logic own_gnt_i = 0, snp_vld_i = 0, ret_ok_i = 0;
    logic [AGE_W-1:0] st_age_i = 0, ld_age_i = 0, ld_ret_age_i = 0;
    logic [ADDR_W-1:0] st_addr_i = 0, ld_addr_i = 0, snp_addr_i = 0;
    logic [DATA_W-1:0] st_data_i = 0;
    logic st_full_o, ld_hit_o, ld_stall_o, own_req_o, own_upg_o, st_ret_o, squash_o;
    logic [DATA_W-1:0] ld_data_o, st_ret_data_o;
    logic [ADDR_W-1:0] own_addr_o, st_ret_addr_o;
    logic [AGE_W-1:0] squash_age_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spec_store_buf uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        {st_vld_i, ld_vld_i, ld_ret_i, own_gnt_i, snp_vld_i, ret_ok_i} = '0;
        repeat (3) tick();
        rst_n = 1;
        tick();
    endtask

    task automatic store(input int age, input int addr, input int data, input bit shr);
        st_vld_i = 1; st_age_i = AGE_W'(age); st_addr_i = ADDR_W'(addr);
        st_data_i = DATA_W'(data); st_shared_i = shr;
        tick();
        st_vld_i = 0;
    endtask

    task automatic load(input string req, input int age, input int addr, input bit hit, input int data);
        ld_vld_i = 1; ld_age_i = AGE_W'(age); ld_addr_i = ADDR_W'(addr);
        #1;
        chk(req, 32'(ld_hit_o), 32'(hit));
        if (hit) chk(req, 32'(ld_data_o), 32'(data));
        tick();
        ld_vld_i = 0;
    endtask

    task automatic snoop(input int addr);
        snp_vld_i = 1; snp_addr_i = ADDR_W'(addr);
        tick();
        snp_vld_i = 0;
    endtask

    task automatic wait_req(input string req, input int addr, input bit upg);
        for (int i = 0; i < 10 && !own_req_o; i++) tick();
        chk(req, 32'(own_req_o), 1);
        chk(req, 32'(own_addr_o), 32'(addr));
        chk(req, 32'(own_upg_o), 32'(upg));
    endtask

    task automatic grant();
        own_gnt_i = 1;
        tick();
        own_gnt_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 full", 32'(st_full_o), 0);
        chk("R1 req", 32'(own_req_o), 0);
        chk("R1 squash", 32'(squash_o), 0);
        ret_ok_i = 1; #1;
        chk("R1 ret", 32'(st_ret_o), 0);
        ret_ok_i = 0;
        load("R1 empty", 5, 5, 0, 0);
    endtask

    task automatic t_forward();
        do_reset();
        store(2, 5, 'hAAAA, 0);
        store(4, 5, 'hBBBB, 0);
        store(6, 7, 'hCCCC, 0);
        load("R2 youngest older", 5, 5, 1, 'hBBBB);
        ld_ret_i = 1; ld_ret_age_i = 5; tick(); ld_ret_i = 0;
        load("R2 older only", 3, 5, 1, 'hAAAA);
        ld_ret_i = 1; ld_ret_age_i = 3; tick(); ld_ret_i = 0;
        load("R2 none older", 1, 5, 0, 0);
        load("R2 other line", 9, 7, 1, 'hCCCC);
    endtask

    task automatic t_own_retire();
        do_reset();
        store(1, 5, 'h1111, 0);
        store(3, 6, 'h2222, 1);
        wait_req("R4 first", 5, 0);
        ret_ok_i = 1; #1;
        chk("R5 unowned head", 32'(st_ret_o), 0);
        ret_ok_i = 0;
        grant();
        wait_req("R4 second upgrade", 6, 1);
        ret_ok_i = 1; #1;
        chk("R5 retire", 32'(st_ret_o), 1);
        chk("R5 addr", 32'(st_ret_addr_o), 5);
        chk("R5 data", 32'(st_ret_data_o), 'h1111);
        tick(); #1;
        chk("R5 next head unowned", 32'(st_ret_o), 0);
        ret_ok_i = 0;
        grant();
        ret_ok_i = 1; #1;
        chk("R5 in order", 32'(st_ret_addr_o), 6);
        chk("R5 second retire", 32'(st_ret_o), 1);
        tick();
        ret_ok_i = 0;
        load("R5 removed", 9, 6, 0, 0);
    endtask

    task automatic t_full();
        do_reset();
        store(1, 1, 'h11, 0);
        store(2, 2, 'h22, 0);
        store(3, 3, 'h33, 0);
        chk("R3 not yet full", 32'(st_full_o), 0);
        store(4, 4, 'h44, 0);
        chk("R3 full", 32'(st_full_o), 1);
        store(5, 8, 'h88, 0);
        load("R3 dropped store", 9, 8, 0, 0);
    endtask

    task automatic t_squash();
        do_reset();
        store(10, 9, 'hA0, 1);
        load("R2 tracked", 12, 9, 1, 'hA0);
        store(14, 3, 'hB0, 0);
        snoop(9);
        chk("R6 squash", 32'(squash_o), 1);
        chk("R6 age", 32'(squash_age_o), 12);
        load("R7 store flushed", 15, 3, 0, 0);
        load("R7 older kept", 11, 9, 1, 'hA0);
        ld_ret_i = 1; ld_ret_age_i = 11; tick(); ld_ret_i = 0;
        snoop(9);
        chk("R7 load untracked", 32'(squash_o), 0);
    endtask

    task automatic t_oldest();
        do_reset();
        store(18, 9, 'h55, 0);
        load("R6 load a", 22, 9, 1, 'h55);
        load("R6 load b", 20, 9, 1, 'h55);
        snoop(9);
        chk("R6 multi squash", 32'(squash_o), 1);
        chk("R6 oldest age", 32'(squash_age_o), 20);
    endtask

    task automatic t_retired();
        do_reset();
        store(1, 7, 'h77, 0);
        load("R9 fwd", 3, 7, 1, 'h77);
        ld_ret_i = 1; ld_ret_age_i = 3; tick(); ld_ret_i = 0;
        snoop(7);
        chk("R9 retired load", 32'(squash_o), 0);
        load("R9 fwd again", 4, 7, 1, 'h77);
        snoop(8);
        chk("R9 other line", 32'(squash_o), 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        store(1, 7, 'h70, 0);
        ld_vld_i = 1; ld_age_i = 5; ld_addr_i = 7;
        snp_vld_i = 1; snp_addr_i = 7;
        #1;
        chk("R10 hit", 32'(ld_hit_o), 1);
        tick();
        ld_vld_i = 0; snp_vld_i = 0;
        chk("R10 squash", 32'(squash_o), 1);
        chk("R10 age", 32'(squash_age_o), 5);
        snoop(7);
        chk("R10 not tracked", 32'(squash_o), 0);
    endtask

    task automatic t_reown();
        do_reset();
        store(2, 4, 'h44, 1);
        wait_req("R8 first upgrade", 4, 1);
        grant();
        ret_ok_i = 1; snp_vld_i = 1; snp_addr_i = 4;
        #1;
        chk("R8 retire blocked", 32'(st_ret_o), 0);
        tick();
        snp_vld_i = 0; #1;
        chk("R8 ownership lost", 32'(st_ret_o), 0);
        ret_ok_i = 0;
        wait_req("R8 re-request", 4, 0);
        grant();
        ret_ok_i = 1; #1;
        chk("R8 retire after regrant", 32'(st_ret_o), 1);
        tick();
        ret_ok_i = 0;
    endtask

    task automatic t_stall();
        do_reset();
        store(1, 6, 'h66, 0);
        load("R11 l2", 2, 6, 1, 'h66);
        load("R11 l3", 3, 6, 1, 'h66);
        load("R11 l4", 4, 6, 1, 'h66);
        load("R11 l5", 5, 6, 1, 'h66);
        ld_vld_i = 1; ld_age_i = 6; ld_addr_i = 6;
        #1;
        chk("R11 stall", 32'(ld_stall_o), 1);
        chk("R11 no hit", 32'(ld_hit_o), 0);
        tick();
        ld_vld_i = 0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_forward();
        t_own_retire();
        t_full();
        t_squash();
        t_oldest();
        t_retired();
        t_same_cycle();
        t_reown();
        t_stall();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R1-watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule